// File: doc/BRIEF.md
# ATA Task-File Register Channel

This block is the device-side register file of one ATA/ATAPI channel. The channel holds two drive slots. A byte-wide host port reaches the command-block registers: error/features, sector count, sector number, cylinder low and high, drive/head, and command/status. It also reaches the control-block registers: device control with alternate status, and drive address. A parameter selects whether the block answers at the primary or the secondary address window. Any address outside the window is ignored.

The block sequences software reset on edges of the reset bit in the device control register. It tracks which drive is selected and masks reads when the selected slot is empty. It decodes a small command set: packet, identify-packet, and abort for every other code. It holds an interrupt request that the interrupt-disable bit gates. Two inputs describe the slots: whether a drive is present, and whether it is a CD-type drive. The data port at offset 0 belongs to a separate buffer block. This block only tells that buffer block when a packet transfer is armed and when identify data must be loaded.

Top module: `ata_taskfile_chan`

## Requirements
- R1: With CHAN=0 the block answers at 0x1F0–0x1F7 and 0x3F6–0x3F7. With CHAN=1 it answers at 0x170–0x177 and 0x376–0x377. Any other address leaves all state unchanged and reads as 0x00.
- R2: A write to the control address that takes bit 2 (soft reset) from 0 to 1 sets status to 0x90, error to 0x01 and command to 0x00. It also clears bit 1 (interrupt disable) and any pending interrupt.
- R3: A write that takes bit 2 from 1 to 0 clears status bit 7 (busy) and sets bit 6 (ready). It zeroes drive/head bits 3:0. In both slots it sets sector count and sector number to 0x01, and sets the cylinder to 0xEB14 in a CD-type slot or 0x0000 otherwise.
- R4: A drive/head write (offset 6) stores the value OR 0xA0. Bit 4 selects the slot. If the new slot is empty, error bit 2 and status bit 0 are set.
- R5: A read at the drive-address location (control base + 1) always returns 0xFF. With the selected slot empty, drive/head reads 0xA0 and every other register reads 0x00.
- R6: A read at offset 1 returns the error register. A read at offset 7 and a read at the control address both return the status byte.
- R7: Command 0xA0 on a CD-type slot sets sector count to 1, clears status bits 7, 5 and 0, sets bit 3 (DRQ), and pulses pkt_start with pkt_len = 12.
- R8: Command 0xA1 sets status to 0x58, zeroes error, raises the interrupt and pulses ident_load.
- R9: Every other command code, and 0xA0 on a slot that is not CD-type, aborts: status 0x41, error 0x04, interrupt raised.
- R10: irq follows the pending interrupt only while control bit 1 is 0. A read at offset 7 clears the pending interrupt; a read at the control address does not.
- R11: After reset: control 0x08, error 0x01, status 0x00, drive/head 0x00, command 0x00, and in each slot sector count 0x01, sector number 0x01, cylinder 0x0000.
- R12: Sector count, sector number and both cylinder bytes are kept per slot and reached through drive/head bit 4. A sector-number write leaves cylinder low unchanged.
- R13: An access at offsets 1–7 or at the control block with acc_bytes ≠ 1 changes nothing. acc_err pulses high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_present | input | 2 | Slot n holds a drive |
| drv_is_cd | input | 2 | Slot n is CD-type |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 16 | Port address |
| wdata | input | 8 | Write byte |
| acc_bytes | input | 3 | Access width in bytes |
| rdata | output | 8 | Read byte (combinational) |
| irq | output | 1 | Interrupt request |
| acc_err | output | 1 | One-cycle pulse after a wide access |
| pkt_start | output | 1 | One-cycle pulse: packet transfer armed |
| pkt_len | output | 4 | Packet length in bytes |
| ident_load | output | 1 | One-cycle pulse: load identify data |

## Verification
The bench sweeps the address space around both windows. This separates the answering offsets and the fixed 0xFF location from foreign addresses and the other channel's window. It writes all 256 values to sector count and to drive/head. These sweeps show per-slot storage and the forced 0xA0 bits across every select and head pattern. It runs the reset edges with a CD-type drive in one slot and a disk in the other. It then runs each command class with the interrupt disable set and with it cleared, so the slot-type reset values, the abort and accept paths, and the interrupt gating can each be told apart. Emptying a slot checks that error flags are latched while reads are masked.

// File: rtl/ata_taskfile_chan.sv
module ata_taskfile_chan #(
  parameter int CHAN      = 0,
  parameter int PKT_BYTES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  drv_present,
  input  logic [1:0]  drv_is_cd,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic [2:0]  acc_bytes,
  output logic [7:0]  rdata,
  output logic        irq,
  output logic        acc_err,
  output logic        pkt_start,
  output logic [3:0]  pkt_len,
  output logic        ident_load
);
  localparam logic [15:0] CMD_BASE = (CHAN == 0) ? 16'h01F0 : 16'h0170;
  localparam logic [15:0] CTL_BASE = (CHAN == 0) ? 16'h03F6 : 16'h0376;

  logic [7:0] err_r, stat_r, cmd_r, ctrl_r, feat_r, dh_r;
  logic [7:0] sc_r [2];
  logic [7:0] sn_r [2];
  logic [7:0] cl_r [2];
  logic [7:0] ch_r [2];
  logic       pend_r;

  wire       hit_cmd = (addr & 16'hFFF8) == CMD_BASE;
  wire       hit_ctl = (addr & 16'hFFFE) == CTL_BASE;
  wire [2:0] off     = addr[2:0];
  wire       tf_hit  = hit_ctl || (hit_cmd && off != 3'd0);
  wire       narrow  = acc_bytes == 3'd1;
  wire       wr_ok   = wr_en && tf_hit && narrow;
  wire       rd_ok   = rd_en && tf_hit && narrow;
  wire       wide    = (wr_en || rd_en) && tf_hit && !narrow;
  wire       sel     = dh_r[4];
  wire       absent  = !drv_present[sel];
  wire       sel_cd  = drv_present[sel] && drv_is_cd[sel];
  wire       wr_ctl  = wr_ok && hit_ctl && !addr[0];
  wire       wr_cmd  = wr_ok && hit_cmd && off == 3'd7;
  wire       wr_dh   = wr_ok && hit_cmd && off == 3'd6;

  assign irq     = pend_r && !ctrl_r[1];
  assign pkt_len = 4'(PKT_BYTES);

  always_comb begin
    rdata = 8'h00;
    if (rd_ok) begin
      if (hit_ctl && addr[0]) rdata = 8'hFF;
      else if (absent) rdata = (hit_cmd && off == 3'd6) ? 8'hA0 : 8'h00;
      else if (hit_ctl) rdata = stat_r;
      else begin
        case (off)
          3'd1: rdata = err_r;
          3'd2: rdata = sc_r[sel];
          3'd3: rdata = sn_r[sel];
          3'd4: rdata = cl_r[sel];
          3'd5: rdata = ch_r[sel];
          3'd6: rdata = dh_r;
          3'd7: rdata = stat_r;
          default: rdata = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_r <= 8'h01; stat_r <= 8'h00; cmd_r <= 8'h00; ctrl_r <= 8'h08;
      feat_r <= 8'h00; dh_r <= 8'h00; pend_r <= 1'b0;
      acc_err <= 1'b0; pkt_start <= 1'b0; ident_load <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        sc_r[i] <= 8'h01; sn_r[i] <= 8'h01; cl_r[i] <= 8'h00; ch_r[i] <= 8'h00;
      end
    end else begin
      acc_err    <= wide;
      pkt_start  <= 1'b0;
      ident_load <= 1'b0;
      if (rd_ok && hit_cmd && off == 3'd7) pend_r <= 1'b0;
      if (wr_ctl) begin
        if (!ctrl_r[2] && wdata[2]) begin
          stat_r <= 8'h90; err_r <= 8'h01; cmd_r <= 8'h00;
          ctrl_r <= wdata & ~8'h02; pend_r <= 1'b0;
        end else begin
          ctrl_r <= wdata;
          if (ctrl_r[2] && !wdata[2]) begin
            stat_r <= {2'b01, stat_r[5:0]};
            dh_r[3:0] <= 4'h0;
            for (int i = 0; i < 2; i++) begin
              sc_r[i] <= 8'h01; sn_r[i] <= 8'h01;
              cl_r[i] <= drv_is_cd[i] ? 8'h14 : 8'h00;
              ch_r[i] <= drv_is_cd[i] ? 8'hEB : 8'h00;
            end
          end
        end
      end
      if (wr_ok && hit_cmd) begin
        case (off)
          3'd1: feat_r <= wdata;
          3'd2: sc_r[sel] <= wdata;
          3'd3: sn_r[sel] <= wdata;
          3'd4: cl_r[sel] <= wdata;
          3'd5: ch_r[sel] <= wdata;
          3'd6: begin
            dh_r <= wdata | 8'hA0;
            if (!drv_present[wdata[4]]) begin
              err_r[2] <= 1'b1; stat_r[0] <= 1'b1;
            end
          end
          3'd7: begin
            cmd_r <= wdata;
            if (wdata == 8'hA0 && sel_cd) begin
              sc_r[sel] <= 8'h01;
              stat_r <= (stat_r & 8'h5E) | 8'h08;
              pkt_start <= 1'b1;
            end else if (wdata == 8'hA1) begin
              stat_r <= 8'h58; err_r <= 8'h00; pend_r <= 1'b1; ident_load <= 1'b1;
            end else begin
              stat_r <= 8'h41; err_r <= 8'h04; pend_r <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_srst_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !ctrl_r[2] && wdata[2]) |=> (stat_r == 8'h90 && err_r == 8'h01 && !ctrl_r[1] && !irq));
  assert_dh_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dh |=> (dh_r[7] && dh_r[5]));
  assert_addr_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && narrow && hit_ctl && addr[0]) |-> rdata == 8'hFF);
  assert_pkt_drq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (stat_r[3] && !stat_r[7] && !stat_r[0]));
  assert_abort_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata != 8'hA0 && wdata != 8'hA1 && !ctrl_r[1] && !wr_ctl) |=> (irq && stat_r == 8'h41));
  assert_wide_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> (acc_err && $stable(dh_r) && $stable(stat_r)));
endmodule

// File: tb/ata_taskfile_chan_tb_top.sv
module ata_taskfile_chan_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] drv_present = 2'b11, drv_is_cd = 2'b10;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [2:0] acc_bytes = 3'd1;
  logic [7:0] rdata;
  logic irq, acc_err, pkt_start, ident_load;
  logic [3:0] pkt_len;
  int n_run = 0, n_fail = 0;
  logic f_err, f_pkt, f_id;
  logic [7:0] v;

  always #2 clk = ~clk;

  ata_taskfile_chan #(.CHAN(0), .PKT_BYTES(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .drv_present(drv_present), .drv_is_cd(drv_is_cd),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .acc_bytes(acc_bytes),
    .rdata(rdata), .irq(irq), .acc_err(acc_err), .pkt_start(pkt_start),
    .pkt_len(pkt_len), .ident_load(ident_load));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] n = 3'd1);
    @(negedge clk); addr = a; wdata = d; acc_bytes = n; wr_en = 1;
    @(negedge clk); wr_en = 0; acc_bytes = 3'd1;
    f_err = acc_err; f_pkt = pkt_start; f_id = ident_load;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; acc_bytes = 3'd1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    // R11 reset values
    rd(16'h03F6, v); chk("R11 status", v, 8'h00);
    rd(16'h01F1, v); chk("R11 error", v, 8'h01);
    rd(16'h01F2, v); chk("R11 sc", v, 8'h01);
    rd(16'h01F3, v); chk("R11 sn", v, 8'h01);
    rd(16'h01F4, v); chk("R11 cl", v, 8'h00);
    rd(16'h01F5, v); chk("R11 ch", v, 8'h00);
    rd(16'h01F6, v); chk("R11 dh", v, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);
    // R1 / R5 address sweep
    for (int a = 16'h03F0; a <= 16'h03FF; a++) begin
      rd(16'(a), v); chk("R1 R5 ctl window", v, (a == 16'h03F7) ? 8'hFF : 8'h00);
    end
    for (int a = 16'h0170; a <= 16'h0177; a++) begin
      rd(16'(a), v); chk("R1 other channel", v, 8'h00);
    end
    for (int a = 16'h01F8; a <= 16'h01FF; a++) begin
      rd(16'(a), v); chk("R1 past window", v, 8'h00);
    end
    wr(16'h0172, 8'h77); rd(16'h01F2, v); chk("R1 foreign write", v, 8'h01);
    // R12 per-drive storage sweep
    for (int x = 0; x < 256; x++) begin
      wr(16'h01F2, 8'(x)); rd(16'h01F2, v); chk("R12 sc sweep", v, 8'(x));
    end
    wr(16'h01F6, 8'h10); rd(16'h01F2, v); chk("R12 slot1 sc", v, 8'h01);
    wr(16'h01F2, 8'h33); wr(16'h01F3, 8'h44);
    rd(16'h01F4, v); chk("R12 sn leaves cl", v, 8'h00);
    wr(16'h01F6, 8'h00); rd(16'h01F2, v); chk("R12 slot0 sc kept", v, 8'hFF);
    rd(16'h01F3, v); chk("R12 slot0 sn", v, 8'h01);
    // R4 dh sweep (both present)
    for (int x = 0; x < 256; x++) begin
      wr(16'h01F6, 8'(x)); rd(16'h01F6, v); chk("R4 dh sweep", v, 8'(x) | 8'hA0);
    end
    rd(16'h01F1, v); chk("R4 no abort when present", v, 8'h01);
    // R13 wide access
    wr(16'h01F6, 8'h00);
    wr(16'h01F2, 8'h99, 3'd2); chk("R13 acc_err", {7'd0, f_err}, 8'h01);
    rd(16'h01F2, v); chk("R13 ignored", v, 8'hFF);
    wr(16'h01F2, 8'h12); chk("R13 no err narrow", {7'd0, f_err}, 8'h00);
    // R7 packet on CD slot
    wr(16'h01F6, 8'h10);
    wr(16'h01F7, 8'hA0);
    chk("R7 pkt_start", {7'd0, f_pkt}, 8'h01);
    chk("R7 pkt_len", {4'd0, pkt_len}, 8'd12);
    rd(16'h01F7, v); chk("R7 status", v, 8'h08);
    rd(16'h01F2, v); chk("R7 sc", v, 8'h01);
    chk("R7 no irq", {7'd0, irq}, 8'h00);
    // R9 abort on disk slot
    wr(16'h01F6, 8'h00);
    wr(16'h01F7, 8'hA0); chk("R9 no pkt", {7'd0, f_pkt}, 8'h00);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    rd(16'h03F6, v); chk("R6 R9 alt status", v, 8'h41);
    chk("R10 alt read keeps irq", {7'd0, irq}, 8'h01);
    rd(16'h01F1, v); chk("R6 R9 error", v, 8'h04);
    rd(16'h01F7, v); chk("R6 R9 status", v, 8'h41);
    chk("R10 status read clears", {7'd0, irq}, 8'h00);
    // R10 gating
    wr(16'h03F6, 8'h02);
    wr(16'h01F7, 8'h55); chk("R10 masked", {7'd0, irq}, 8'h00);
    wr(16'h03F6, 8'h00); chk("R10 unmasked", {7'd0, irq}, 8'h01);
    rd(16'h01F7, v); chk("R10 cleared", {7'd0, irq}, 8'h00);
    // R8 identify packet
    wr(16'h01F7, 8'hA1); chk("R8 ident_load", {7'd0, f_id}, 8'h01);
    chk("R8 irq", {7'd0, irq}, 8'h01);
    rd(16'h01F1, v); chk("R8 error", v, 8'h00);
    rd(16'h01F7, v); chk("R8 status", v, 8'h58);
    // R2 / R3 soft reset
    wr(16'h01F2, 8'h22);
    wr(16'h01F6, 8'h1F); wr(16'h01F4, 8'h33);
    wr(16'h03F6, 8'h04);
    rd(16'h01F7, v); chk("R2 status", v, 8'h90);
    rd(16'h01F1, v); chk("R2 error", v, 8'h01);
    wr(16'h03F6, 8'h00);
    rd(16'h01F7, v); chk("R3 status", v, 8'h50);
    rd(16'h01F6, v); chk("R3 head cleared", v, 8'hB0);
    rd(16'h01F4, v); chk("R3 cd cl", v, 8'h14);
    rd(16'h01F5, v); chk("R3 cd ch", v, 8'hEB);
    rd(16'h01F3, v); chk("R3 cd sn", v, 8'h01);
    wr(16'h01F6, 8'h00);
    rd(16'h01F2, v); chk("R3 disk sc", v, 8'h01);
    rd(16'h01F5, v); chk("R3 disk ch", v, 8'h00);
    // R4 / R5 absent slot
    drv_present = 2'b01;
    wr(16'h01F6, 8'h10);
    rd(16'h01F6, v); chk("R5 absent dh", v, 8'hA0);
    rd(16'h01F1, v); chk("R5 absent err", v, 8'h00);
    rd(16'h03F6, v); chk("R5 absent alt", v, 8'h00);
    rd(16'h03F7, v); chk("R5 absent addr", v, 8'hFF);
    wr(16'h01F6, 8'h00);
    rd(16'h01F1, v); chk("R4 abort bit", v, 8'h05);
    rd(16'h03F6, v); chk("R4 err status bit", v, 8'h51);
    // R2 interrupt-disable cleared by reset rise
    drv_present = 2'b11;
    wr(16'h03F6, 8'h02); wr(16'h03F6, 8'h06);
    wr(16'h01F7, 8'h55); chk("R2 nien cleared", {7'd0, irq}, 8'h01);
    rd(16'h01F7, v); wr(16'h03F6, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule